// File: doc/BRIEF.md
# Virtually Indexed, Physically Tagged Write-Back Data Cache

This block is the first-level data cache of a single core. The core issues 32-bit loads and stores by page-offset word address. The set is selected from that offset alone, so the tag and data arrays are read in parallel with the address translation. The translation unit is modelled as an input that returns the physical page number one cycle after a request is accepted. The hit decision compares that page number against the physical tags of the eight ways of the set. Because every index bit sits inside the 4 KiB page offset, two virtual pages that map to one physical page always select the same set. No alias can form, and nothing has to be flushed when the address space changes.

Stores update the cached line and mark it dirty. Memory sees modified data only when the line is replaced. A miss blocks the core port until it is resolved. If the chosen victim is dirty, its whole line is written to the next level first. The missing line is then requested, installed, and the access is replayed as a hit. An empty way is always used before any resident line is displaced. When all ways are full, a binary-tree pseudo-LRU picks the victim.

Top module: `vipt_dcache`

## Requirements
- R1: A line is 64 bytes (16 words of 32 bits). Word w of a line occupies bits [32*w+31 : 32*w] of the line transferred on the memory port. The low 4 bits of `req_waddr` select the word.
- R2: The set is `req_waddr[9:4]` (64 sets). Every memory request carries the line address {page number, set}, so its low 6 bits equal the set of the access being served.
- R3: `tlb_ppn` is sampled only in the first cycle after a request is accepted, and its value at any other time has no effect. A hit requires a valid way whose stored physical page number equals the sampled one. A different page number at the same page offset misses.
- R4: A load hit raises `rsp_valid` for exactly one cycle, on the second rising edge after acceptance, with the addressed word. It causes no memory request.
- R5: A store hit updates the word in the cache and issues no memory write. A later load of that word returns the stored value.
- R6: On a miss whose victim is dirty, the victim's full line is written to {old page number, set}. The fill read for the new line follows in the cycle after the write is accepted. The written line carries every store made to it.
- R7: A miss whose victim is clean issues only the fill read, with no memory write.
- R8: The cache is 8-way set associative, and invalid ways are filled before any valid way is replaced. Eight distinct lines in one set therefore all stay resident.
- R9: With all 8 ways valid, the victim follows a 7-node binary pseudo-LRU tree. After the ways are touched in the order 0,1,...,7 and then 0 again, the next miss replaces way 4.
- R10: Only one miss is outstanding. `req_ready` is low from acceptance until the response, and no response is given while a memory request is pending.
- R11: A store miss fetches the line, merges the stored word, and marks the line dirty. The other words keep their memory values.
- R12: After reset `req_ready` is high, `rsp_valid` and `mem_req_valid` are low, and every way is invalid, so the first access to any set misses.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| req_valid | input | 1 | Core request present |
| req_ready | output | 1 | Cache can accept a request |
| req_write | input | 1 | 1 = store, 0 = load |
| req_waddr | input | 10 | Word address within the 4 KiB page |
| req_wdata | input | 32 | Store data |
| rsp_valid | output | 1 | Access completed |
| rsp_rdata | output | 32 | Load data (word before the store, for stores) |
| tlb_ppn | input | 20 | Physical page number, valid the cycle after acceptance |
| mem_req_valid | output | 1 | Line request to next level |
| mem_req_ready | input | 1 | Next level accepts the request |
| mem_req_write | output | 1 | 1 = write-back of a line, 0 = fill read |
| mem_req_addr | output | 26 | Physical line address {page number, set} |
| mem_req_wdata | output | 512 | Write-back line data |
| mem_rsp_valid | input | 1 | Fill data present |
| mem_rsp_rdata | input | 512 | Fill line data |

## Verification
The interesting collision is a replacement of a dirty way. Evicting the old line and fetching the new one land on the same set and way, back to back, and the old line's data must leave before the way is overwritten. The bench makes all eight ways of one set dirty through stores, touches them in a fixed order, and then misses on a ninth page. It judges the exact evicted address against the tree order, the stored word inside the written line, and that the write is logged before the fill read. A second collision is a store miss, where the fill and the store merge into the same line. It is judged by reading back both the stored word and an untouched word of that line.

// File: rtl/dc_pkg.sv
// Shared types of the data cache.
// Assumes nothing beyond SystemVerilog packages being compiled first.
package dc_pkg;
    typedef enum logic [2:0] {
        ST_IDLE,
        ST_LOOKUP,
        ST_WBACK,
        ST_FILL_REQ,
        ST_FILL_WAIT
    } dc_state_e;
endpackage

// File: rtl/dc_tag_store.sv
// Per-way valid, dirty and physical-tag arrays with the tag comparators.
// Assumes the set index is held stable by the controller during a lookup.
// A fill sets valid and clears dirty; a store sets dirty.
module dc_tag_store #(
    parameter int SETS     = 64,
    parameter int WAYS     = 8,
    parameter int TAG_BITS = 20,
    parameter int IDX_BITS = $clog2(SETS),
    parameter int WAY_BITS = $clog2(WAYS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_BITS-1:0] idx,
    input  logic [TAG_BITS-1:0] cmp_tag,
    input  logic                fill_en,
    input  logic [WAY_BITS-1:0] fill_way,
    input  logic [TAG_BITS-1:0] fill_tag,
    input  logic                dirty_en,
    input  logic [WAY_BITS-1:0] dirty_way,
    input  logic [WAY_BITS-1:0] vic_way,
    output logic [WAYS-1:0]     hit_vec,
    output logic [WAYS-1:0]     valid_vec,
    output logic [WAYS-1:0]     dirty_vec,
    output logic [TAG_BITS-1:0] vic_tag
);
    logic [TAG_BITS-1:0] way_tag [WAYS];

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [SETS-1:0]     valid_q;
        logic [SETS-1:0]     dirty_q;
        logic [TAG_BITS-1:0] tag_q [SETS];

        // Track line state bits of this way.
        always_ff @(posedge clk) begin
            if (!rst_n) begin
                valid_q <= '0;
                dirty_q <= '0;
            end else begin
                if (fill_en && fill_way == WAY_BITS'(w)) begin
                    valid_q[idx] <= 1'b1;
                    dirty_q[idx] <= 1'b0;
                end
                if (dirty_en && dirty_way == WAY_BITS'(w)) begin
                    dirty_q[idx] <= 1'b1;
                end
            end
        end

        // Record the physical tag of a newly installed line.
        always_ff @(posedge clk) begin
            if (fill_en && fill_way == WAY_BITS'(w)) begin
                tag_q[idx] <= fill_tag;
            end
        end

        assign hit_vec[w]   = valid_q[idx] && (tag_q[idx] == cmp_tag);
        assign valid_vec[w] = valid_q[idx];
        assign dirty_vec[w] = dirty_q[idx];
        assign way_tag[w]   = tag_q[idx];
    end

    assign vic_tag = way_tag[vic_way];
endmodule

// File: rtl/dc_data_store.sv
// Line storage for all ways, with one word port for hits and one line port
// for write-back. Assumes fill and word write never target the same way in
// the same cycle (the controller keeps them in different states).
module dc_data_store #(
    parameter int SETS      = 64,
    parameter int WAYS      = 8,
    parameter int LINE_BITS = 512,
    parameter int WORD_BITS = 32,
    parameter int IDX_BITS  = $clog2(SETS),
    parameter int WAY_BITS  = $clog2(WAYS),
    parameter int WSEL_BITS = $clog2(LINE_BITS / WORD_BITS)
) (
    input  logic                 clk,
    input  logic [IDX_BITS-1:0]  idx,
    input  logic [WAY_BITS-1:0]  word_way,
    input  logic [WSEL_BITS-1:0] wsel,
    input  logic                 wr_en,
    input  logic [WORD_BITS-1:0] wr_word,
    input  logic                 fill_en,
    input  logic [WAY_BITS-1:0]  fill_way,
    input  logic [LINE_BITS-1:0] fill_line,
    input  logic [WAY_BITS-1:0]  line_way,
    output logic [WORD_BITS-1:0] rd_word,
    output logic [LINE_BITS-1:0] rd_line
);
    logic [LINE_BITS-1:0] way_line [WAYS];
    logic [LINE_BITS-1:0] word_src;

    for (genvar w = 0; w < WAYS; w++) begin : g_way
        logic [LINE_BITS-1:0] line_q [SETS];

        // Install a fetched line or merge a stored word.
        always_ff @(posedge clk) begin
            if (fill_en && fill_way == WAY_BITS'(w)) begin
                line_q[idx] <= fill_line;
            end else if (wr_en && word_way == WAY_BITS'(w)) begin
                line_q[idx][wsel*WORD_BITS +: WORD_BITS] <= wr_word;
            end
        end

        assign way_line[w] = line_q[idx];
    end

    assign word_src = way_line[word_way];
    assign rd_word  = word_src[wsel*WORD_BITS +: WORD_BITS];
    assign rd_line  = way_line[line_way];
endmodule

// File: rtl/dc_plru.sv
// Per-set binary-tree pseudo-LRU with invalid-way preference.
// Tree node n (1-based heap) is bit n-1; a bit of 1 points the victim walk
// to the right child. Touching a way points every node on its path away.
// Assumes WAYS is a power of two and at least 2.
module dc_plru #(
    parameter int SETS     = 64,
    parameter int WAYS     = 8,
    parameter int IDX_BITS = $clog2(SETS),
    parameter int WAY_BITS = $clog2(WAYS)
) (
    input  logic                clk,
    input  logic                rst_n,
    input  logic [IDX_BITS-1:0] idx,
    input  logic [WAYS-1:0]     valid_vec,
    input  logic                touch_en,
    input  logic [WAY_BITS-1:0] touch_way,
    output logic [WAY_BITS-1:0] victim
);
    logic [WAYS-2:0] tree_q [SETS];
    logic [WAYS-2:0] cur;
    logic [WAYS-2:0] nxt;

    assign cur = tree_q[idx];

    // Pick the lowest invalid way, else walk the tree.
    always_comb begin
        logic found;
        int   n;
        victim = '0;
        found  = 1'b0;
        n      = 1;
        for (int w = 0; w < WAYS; w++) begin
            if (!found && !valid_vec[w]) begin
                victim = WAY_BITS'(w);
                found  = 1'b1;
            end
        end
        if (!found) begin
            for (int l = 0; l < WAY_BITS; l++) begin
                n = 2 * n + int'(cur[n-1]);
            end
            victim = WAY_BITS'(n - WAYS);
        end
    end

    // Compute tree bits after touching a way.
    always_comb begin
        int m;
        logic dir;
        nxt = cur;
        m   = 1;
        for (int l = 0; l < WAY_BITS; l++) begin
            dir      = touch_way[WAY_BITS-1-l];
            nxt[m-1] = ~dir;
            m        = 2 * m + int'(dir);
        end
    end

    // Store updated tree of the accessed set.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            for (int s = 0; s < SETS; s++) tree_q[s] <= '0;
        end else if (touch_en) begin
            tree_q[idx] <= nxt;
        end
    end
endmodule

// File: rtl/vipt_dcache.sv
// Level-one data cache, virtually indexed and physically tagged, write-back,
// set associative, blocking on one miss. The set comes from the page offset,
// the tag from the page number returned by translation one cycle after a
// request is accepted. A miss writes back a dirty victim, fetches the line and
// replays the access as a hit. Assumes OFF_BITS + IDX_BITS == PAGE_BITS.
module vipt_dcache #(
    parameter int SETS       = 64,
    parameter int WAYS       = 8,
    parameter int LINE_BYTES = 64,
    parameter int WORD_BITS  = 32,
    parameter int PAGE_BITS  = 12,
    parameter int PPN_BITS   = 20
) (
    input  logic                                        clk,
    input  logic                                        rst_n,
    input  logic                                        req_valid,
    output logic                                        req_ready,
    input  logic                                        req_write,
    input  logic [PAGE_BITS-$clog2(WORD_BITS/8)-1:0]    req_waddr,
    input  logic [WORD_BITS-1:0]                        req_wdata,
    output logic                                        rsp_valid,
    output logic [WORD_BITS-1:0]                        rsp_rdata,
    input  logic [PPN_BITS-1:0]                         tlb_ppn,
    output logic                                        mem_req_valid,
    input  logic                                        mem_req_ready,
    output logic                                        mem_req_write,
    output logic [PPN_BITS+$clog2(SETS)-1:0]            mem_req_addr,
    output logic [LINE_BYTES*8-1:0]                     mem_req_wdata,
    input  logic                                        mem_rsp_valid,
    input  logic [LINE_BYTES*8-1:0]                     mem_rsp_rdata
);
    import dc_pkg::*;

    localparam int LINE_BITS  = LINE_BYTES * 8;
    localparam int IDX_BITS   = $clog2(SETS);
    localparam int WAY_BITS   = $clog2(WAYS);
    localparam int WSEL_BITS  = $clog2(LINE_BITS / WORD_BITS);
    localparam int WADDR_BITS = PAGE_BITS - $clog2(WORD_BITS / 8);
    localparam int LADDR_BITS = PPN_BITS + IDX_BITS;

    dc_state_e             state_q;
    logic [IDX_BITS-1:0]   idx_q;
    logic [WSEL_BITS-1:0]  wsel_q;
    logic                  wr_q;
    logic [WORD_BITS-1:0]  wdata_q;
    logic [PPN_BITS-1:0]   ppn_q;
    logic [PPN_BITS-1:0]   vtag_q;
    logic [WAY_BITS-1:0]   vway_q;
    logic                  replay_q;
    logic                  rsp_valid_q;
    logic [WORD_BITS-1:0]  rsp_rdata_q;

    logic [PPN_BITS-1:0]   eff_ppn;
    logic [WAYS-1:0]       hit_vec;
    logic [WAYS-1:0]       valid_vec;
    logic [WAYS-1:0]       dirty_vec;
    logic [PPN_BITS-1:0]   vic_tag;
    logic [WAY_BITS-1:0]   victim;
    logic [WAY_BITS-1:0]   hit_way;
    logic                  lookup_hit;
    logic                  store_en;
    logic                  fill_en;
    logic [WORD_BITS-1:0]  rd_word;
    logic [LINE_BITS-1:0]  rd_line;

    // First lookup uses the fresh translation, a replay the saved one.
    assign eff_ppn    = replay_q ? ppn_q : tlb_ppn;
    assign lookup_hit = (state_q == ST_LOOKUP) && (|hit_vec);
    assign store_en   = lookup_hit && wr_q;
    assign fill_en    = (state_q == ST_FILL_WAIT) && mem_rsp_valid;

    // Encode the matching way.
    always_comb begin
        hit_way = '0;
        for (int w = 0; w < WAYS; w++) begin
            if (hit_vec[w]) hit_way = WAY_BITS'(w);
        end
    end

    dc_tag_store #(
        .SETS(SETS), .WAYS(WAYS), .TAG_BITS(PPN_BITS)
    ) tags_i (
        .clk(clk), .rst_n(rst_n), .idx(idx_q), .cmp_tag(eff_ppn),
        .fill_en(fill_en), .fill_way(vway_q), .fill_tag(ppn_q),
        .dirty_en(store_en), .dirty_way(hit_way), .vic_way(victim),
        .hit_vec(hit_vec), .valid_vec(valid_vec), .dirty_vec(dirty_vec),
        .vic_tag(vic_tag)
    );

    dc_data_store #(
        .SETS(SETS), .WAYS(WAYS), .LINE_BITS(LINE_BITS), .WORD_BITS(WORD_BITS)
    ) data_i (
        .clk(clk), .idx(idx_q), .word_way(hit_way), .wsel(wsel_q),
        .wr_en(store_en), .wr_word(wdata_q),
        .fill_en(fill_en), .fill_way(vway_q), .fill_line(mem_rsp_rdata),
        .line_way(vway_q), .rd_word(rd_word), .rd_line(rd_line)
    );

    dc_plru #(
        .SETS(SETS), .WAYS(WAYS)
    ) plru_i (
        .clk(clk), .rst_n(rst_n), .idx(idx_q), .valid_vec(valid_vec),
        .touch_en(lookup_hit), .touch_way(hit_way), .victim(victim)
    );

    // Sequence requests through lookup, write-back, fill and replay.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            state_q     <= ST_IDLE;
            idx_q       <= '0;
            wsel_q      <= '0;
            wr_q        <= 1'b0;
            wdata_q     <= '0;
            ppn_q       <= '0;
            vtag_q      <= '0;
            vway_q      <= '0;
            replay_q    <= 1'b0;
            rsp_valid_q <= 1'b0;
            rsp_rdata_q <= '0;
        end else begin
            rsp_valid_q <= 1'b0;
            case (state_q)
                ST_IDLE: begin
                    if (req_valid) begin
                        idx_q   <= req_waddr[WADDR_BITS-1:WSEL_BITS];
                        wsel_q  <= req_waddr[WSEL_BITS-1:0];
                        wr_q    <= req_write;
                        wdata_q <= req_wdata;
                        state_q <= ST_LOOKUP;
                    end
                end
                ST_LOOKUP: begin
                    if (|hit_vec) begin
                        rsp_valid_q <= 1'b1;
                        rsp_rdata_q <= rd_word;
                        replay_q    <= 1'b0;
                        state_q     <= ST_IDLE;
                    end else begin
                        ppn_q  <= eff_ppn;
                        vway_q <= victim;
                        vtag_q <= vic_tag;
                        state_q <= (valid_vec[victim] && dirty_vec[victim]) ?
                                   ST_WBACK : ST_FILL_REQ;
                    end
                end
                ST_WBACK: begin
                    if (mem_req_ready) state_q <= ST_FILL_REQ;
                end
                ST_FILL_REQ: begin
                    if (mem_req_ready) state_q <= ST_FILL_WAIT;
                end
                ST_FILL_WAIT: begin
                    if (mem_rsp_valid) begin
                        replay_q <= 1'b1;
                        state_q  <= ST_LOOKUP;
                    end
                end
                default: state_q <= ST_IDLE;
            endcase
        end
    end

    assign req_ready     = (state_q == ST_IDLE);
    assign rsp_valid     = rsp_valid_q;
    assign rsp_rdata     = rsp_rdata_q;
    assign mem_req_valid = (state_q == ST_WBACK) || (state_q == ST_FILL_REQ);
    assign mem_req_write = (state_q == ST_WBACK);
    assign mem_req_addr  = (state_q == ST_WBACK) ? LADDR_BITS'({vtag_q, idx_q})
                                                 : LADDR_BITS'({ppn_q, idx_q});
    assign mem_req_wdata = rd_line;
endmodule

// File: rtl/dcache_chk.sv
// Temporal checks on the cache ports. Holds the set of the accepted request
// so that memory addresses can be related to it.
module dcache_chk #(
    parameter int IDX_BITS   = 6,
    parameter int LADDR_BITS = 26
) (
    input  logic                  clk,
    input  logic                  rst_n,
    input  logic                  req_valid,
    input  logic                  req_ready,
    input  logic [IDX_BITS-1:0]   req_idx,
    input  logic                  mem_req_valid,
    input  logic                  mem_req_ready,
    input  logic                  mem_req_write,
    input  logic [LADDR_BITS-1:0] mem_req_addr,
    input  logic                  mem_rsp_valid,
    input  logic                  rsp_valid
);
    logic [IDX_BITS-1:0] idx_cap;

    // Remember the set of the request being served.
    always_ff @(posedge clk) begin
        if (!rst_n) idx_cap <= '0;
        else if (req_valid && req_ready) idx_cap <= req_idx;
    end

    p_mem_index_r2: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> mem_req_addr[IDX_BITS-1:0] == idx_cap);

    p_resp_pulse_r4: assert property (@(posedge clk) disable iff (!rst_n)
        rsp_valid |=> !rsp_valid);

    p_wb_then_fill_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && mem_req_write && mem_req_ready) |=>
        (mem_req_valid && !mem_req_write));

    p_req_hold_r6: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid && !mem_req_ready) |=>
        (mem_req_valid && $stable(mem_req_addr) && $stable(mem_req_write)));

    p_stall_r10: assert property (@(posedge clk) disable iff (!rst_n)
        (mem_req_valid || mem_rsp_valid) |-> !req_ready);

    p_no_rsp_in_miss_r10: assert property (@(posedge clk) disable iff (!rst_n)
        mem_req_valid |-> !rsp_valid);
endmodule

bind vipt_dcache dcache_chk #(
    .IDX_BITS(IDX_BITS), .LADDR_BITS(LADDR_BITS)
) chk_i (
    .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
    .req_idx(req_waddr[WADDR_BITS-1:WSEL_BITS]),
    .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
    .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
    .mem_rsp_valid(mem_rsp_valid), .rsp_valid(rsp_valid)
);

// File: tb/vipt_dcache_tb_top.sv
// Bench: sweeps every set, then drives replacement, store-merge and
// translation-timing cases against a line memory model.
module vipt_dcache_tb_top;
    localparam int CLK_PERIOD = 10;
    localparam int LB = 512;
    localparam int LA = 26;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    logic req_valid = 1'b0;
    logic req_ready;
    logic req_write = 1'b0;
    logic [9:0] req_waddr = '0;
    logic [31:0] req_wdata = '0;
    logic rsp_valid;
    logic [31:0] rsp_rdata;
    logic [19:0] tlb_ppn = '0;
    logic mem_req_valid;
    logic mem_req_ready = 1'b0;
    logic mem_req_write;
    logic [LA-1:0] mem_req_addr;
    logic [LB-1:0] mem_req_wdata;
    logic mem_rsp_valid = 1'b0;
    logic [LB-1:0] mem_rsp_rdata = '0;

    int checks = 0;
    int fails = 0;
    int cyc = 0;
    int rd_count = 0, wr_count = 0, ev_seq = 0, rd_seq = 0, wr_seq = 0;
    logic [LA-1:0] last_rd_addr = '0, last_wr_addr = '0;
    logic [LB-1:0] mem_lines [logic [LA-1:0]];
    logic [31:0] shadow [logic [29:0]];
    logic [LA-1:0] pend_addr = '0;
    int rsp_cnt = 0;
    int rdy_cnt = 0;

    vipt_dcache dut_i (
        .clk(clk), .rst_n(rst_n), .req_valid(req_valid), .req_ready(req_ready),
        .req_write(req_write), .req_waddr(req_waddr), .req_wdata(req_wdata),
        .rsp_valid(rsp_valid), .rsp_rdata(rsp_rdata), .tlb_ppn(tlb_ppn),
        .mem_req_valid(mem_req_valid), .mem_req_ready(mem_req_ready),
        .mem_req_write(mem_req_write), .mem_req_addr(mem_req_addr),
        .mem_req_wdata(mem_req_wdata), .mem_rsp_valid(mem_rsp_valid),
        .mem_rsp_rdata(mem_rsp_rdata)
    );

    always #(CLK_PERIOD/2) clk = ~clk;

    function automatic logic [31:0] init_word(logic [LA-1:0] la, int w);
        return (32'(la) * 32'h0001_0003) ^ (32'(w) * 32'h1111);
    endfunction

    function automatic logic [LB-1:0] mem_line(logic [LA-1:0] la);
        logic [LB-1:0] l;
        if (mem_lines.exists(la)) return mem_lines[la];
        for (int w = 0; w < 16; w++) l[w*32 +: 32] = init_word(la, w);
        return l;
    endfunction

    function automatic logic [31:0] exp_word(logic [19:0] ppn, int set, int w);
        logic [29:0] k;
        k = {ppn, 6'(set), 4'(w)};
        if (shadow.exists(k)) return shadow[k];
        return init_word({ppn, 6'(set)}, w);
    endfunction

    // Next-level memory model: ready pattern, write logging, delayed fill.
    always @(negedge clk) begin
        mem_rsp_valid = 1'b0;
        if (rsp_cnt == 1) begin
            mem_rsp_valid = 1'b1;
            mem_rsp_rdata = mem_line(pend_addr);
        end
        if (rsp_cnt > 0) rsp_cnt--;
        rdy_cnt++;
        mem_req_ready = (rdy_cnt % 3) != 0;
        if (mem_req_valid && mem_req_ready) begin
            ev_seq++;
            if (mem_req_write) begin
                mem_lines[mem_req_addr] = mem_req_wdata;
                last_wr_addr = mem_req_addr;
                wr_count++;
                wr_seq = ev_seq;
            end else begin
                pend_addr = mem_req_addr;
                rsp_cnt = 3;
                last_rd_addr = mem_req_addr;
                rd_count++;
                rd_seq = ev_seq;
            end
        end
    end

    // Watchdog ending a hung run as a failure.
    always @(posedge clk) begin
        cyc++;
        if (cyc > 150000) begin
            fails++;
            $display("FAIL watchdog actual=%0d expected<=150000 cycles", cyc);
            $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
            $finish;
        end
    end

    task automatic chk(input bit ok, input string req, input logic [63:0] act,
                       input logic [63:0] exp);
        checks++;
        if (!ok) begin
            fails++;
            $display("FAIL %s actual=%h expected=%h", req, act, exp);
        end
    endtask

    task automatic access(input bit wr, input logic [19:0] ppn, input int set,
                          input int w, input logic [31:0] wd,
                          output logic [31:0] rd, output int lat,
                          output bit busy_ok);
        @(negedge clk);
        while (!req_ready) @(negedge clk);
        req_valid = 1'b1;
        req_write = wr;
        req_waddr = {6'(set), 4'(w)};
        req_wdata = wd;
        @(negedge clk);
        req_valid = 1'b0;
        tlb_ppn = ppn;
        @(negedge clk);
        tlb_ppn = ~ppn;
        lat = 1;
        busy_ok = 1'b1;
        while (!rsp_valid && lat < 200) begin
            if (req_ready) busy_ok = 1'b0;
            @(negedge clk);
            lat++;
        end
        rd = rsp_rdata;
        if (wr) shadow[{ppn, 6'(set), 4'(w)}] = wd;
    endtask

    initial begin
        logic [31:0] rd;
        int lat, r0, w0;
        bit busy;
        logic [LB-1:0] l;

        repeat (3) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk(req_ready == 1'b1, "R12 ready after reset", 64'(req_ready), 64'd1);
        chk(rsp_valid == 1'b0, "R12 no response after reset", 64'(rsp_valid), 64'd0);
        chk(mem_req_valid == 1'b0, "R12 no memory request after reset",
            64'(mem_req_valid), 64'd0);

        // Sweep every set: cold miss, then hit on another word.
        for (int s = 0; s < 64; s++) begin
            r0 = rd_count;
            access(1'b0, 20'h00012, s, s % 16, '0, rd, lat, busy);
            chk(rd_count == r0 + 1, "R12 cold miss fetches", 64'(rd_count), 64'(r0 + 1));
            chk(last_rd_addr == {20'h00012, 6'(s)}, "R2 fill line address",
                64'(last_rd_addr), 64'({20'h00012, 6'(s)}));
            chk(rd == exp_word(20'h00012, s, s % 16), "R1 miss word data",
                64'(rd), 64'(exp_word(20'h00012, s, s % 16)));
            chk(busy, "R10 ready low during miss", 64'(busy), 64'd1);
            r0 = rd_count;
            access(1'b0, 20'h00012, s, (s + 1) % 16, '0, rd, lat, busy);
            chk(lat == 1, "R4 hit latency", 64'(lat), 64'd1);
            chk(rd_count == r0, "R4 hit no memory traffic", 64'(rd_count), 64'(r0));
            chk(rd == exp_word(20'h00012, s, (s + 1) % 16), "R1 hit word data",
                64'(rd), 64'(exp_word(20'h00012, s, (s + 1) % 16)));
        end

        // Same page offset, other physical page: tag mismatch.
        r0 = rd_count;
        access(1'b0, 20'h00013, 5, 3, '0, rd, lat, busy);
        chk(rd_count == r0 + 1, "R3 other page misses", 64'(rd_count), 64'(r0 + 1));
        chk(rd == exp_word(20'h00013, 5, 3), "R3 other page data",
            64'(rd), 64'(exp_word(20'h00013, 5, 3)));
        access(1'b0, 20'h00012, 5, 7, '0, rd, lat, busy);
        chk(lat == 1, "R3 original page still hits", 64'(lat), 64'd1);

        // Store hit stays in the cache.
        w0 = wr_count;
        access(1'b1, 20'h00012, 7, 4, 32'hFACE_0007, rd, lat, busy);
        chk(lat == 1, "R5 store hit latency", 64'(lat), 64'd1);
        access(1'b0, 20'h00012, 7, 4, '0, rd, lat, busy);
        chk(rd == 32'hFACE_0007, "R5 load sees store", 64'(rd), 64'hFACE_0007);
        chk(wr_count == w0, "R5 no write on store hit", 64'(wr_count), 64'(w0));

        // Store miss: fetch, merge, keep other words.
        access(1'b1, 20'h00040, 9, 1, 32'hBEEF_0009, rd, lat, busy);
        chk(lat > 1, "R11 store miss fetches", 64'(lat), 64'd2);
        access(1'b0, 20'h00040, 9, 1, '0, rd, lat, busy);
        chk(rd == 32'hBEEF_0009 && lat == 1, "R11 merged word", 64'(rd), 64'hBEEF_0009);
        access(1'b0, 20'h00040, 9, 2, '0, rd, lat, busy);
        chk(rd == exp_word(20'h00040, 9, 2), "R11 untouched word",
            64'(rd), 64'(exp_word(20'h00040, 9, 2)));
        chk(wr_count == w0, "R11 no write-back yet", 64'(wr_count), 64'(w0));

        // Fill set 30 with 8 dirty lines, touched in way order 0..7.
        w0 = wr_count;
        access(1'b1, 20'h00012, 30, 0, 32'hA000_0000, rd, lat, busy);
        for (int k = 1; k < 8; k++)
            access(1'b1, 20'h00100 + 20'(k), 30, k, 32'hA000_0000 + 32'(k), rd, lat, busy);
        chk(wr_count == w0, "R8 invalid ways used first", 64'(wr_count), 64'(w0));
        r0 = rd_count;
        for (int k = 0; k < 8; k++) begin
            access(1'b0, (k == 0) ? 20'h00012 : 20'h00100 + 20'(k), 30, k, '0, rd, lat, busy);
            chk(rd == 32'hA000_0000 + 32'(k), "R8 all eight resident",
                64'(rd), 64'(32'hA000_0000 + 32'(k)));
        end
        chk(rd_count == r0, "R8 no refetch of resident lines", 64'(rd_count), 64'(r0));
        access(1'b0, 20'h00012, 30, 0, '0, rd, lat, busy);
        access(1'b0, 20'h00108, 30, 2, '0, rd, lat, busy);
        chk(wr_count == w0 + 1, "R6 dirty victim written", 64'(wr_count), 64'(w0 + 1));
        chk(last_wr_addr == {20'h00104, 6'd30}, "R9 tree victim is way 4",
            64'(last_wr_addr), 64'({20'h00104, 6'd30}));
        l = mem_line({20'h00104, 6'd30});
        chk(l[4*32 +: 32] == 32'hA000_0004, "R6 written line carries store",
            64'(l[4*32 +: 32]), 64'hA000_0004);
        chk(wr_seq < rd_seq, "R6 write-back before fill", 64'(wr_seq), 64'(rd_seq));
        chk(last_rd_addr == {20'h00108, 6'd30}, "R6 fill address",
            64'(last_rd_addr), 64'({20'h00108, 6'd30}));
        chk(rd == exp_word(20'h00108, 30, 2), "R1 new line data",
            64'(rd), 64'(exp_word(20'h00108, 30, 2)));
        access(1'b0, 20'h00104, 30, 4, '0, rd, lat, busy);
        chk(rd == 32'hA000_0004, "R6 evicted data returns", 64'(rd), 64'hA000_0004);

        // Clean replacements in set 40.
        w0 = wr_count;
        r0 = rd_count;
        for (int k = 1; k <= 8; k++) begin
            access(1'b0, 20'h00200 + 20'(k), 40, 0, '0, rd, lat, busy);
            chk(rd == exp_word(20'h00200 + 20'(k), 40, 0), "R7 clean fill data",
                64'(rd), 64'(exp_word(20'h00200 + 20'(k), 40, 0)));
        end
        chk(rd_count == r0 + 8, "R7 one fill per miss", 64'(rd_count), 64'(r0 + 8));
        chk(wr_count == w0, "R7 no write for clean victim", 64'(wr_count), 64'(w0));

        $display("TB_RESULT checks=%0d failures=%0d", checks, fails);
        $finish;
    end
endmodule